// File: doc/BRIEF.md
# Bridge Memory Window Forwarding Decoder

This block sits on the upstream side of a PCI-to-PCI bridge root port and decides, for each memory request it sees, whether the request is claimed and sent downstream. Two address windows are held in configuration registers. The first window covers only non-prefetchable space below 4 GB. The second window covers prefetchable space and reaches across the full 64-bit address range through two extra upper-half registers.

Software programs the windows through a simple register write port with a combinational read-back. Each 16-bit bound register carries address bits [31:20] in its upper twelve bits, so both windows move in 1 MB steps. Base bounds fill the low 20 bits with zeros and limit bounds fill them with ones. A request presents an address, a flag that marks a 64-bit address and a valid strobe. One clock later the block returns a registered decision with a single-cycle valid pulse.

Top module: `mem_window_decoder`

## Requirements
- R1: After reset both windows are disabled, the memory enable bit is clear, and no request is forwarded or hits either window.
- R2: The non-prefetchable window spans from {fld,20'h00000} to {fld_lim,20'hFFFFF}, where fld is bits [15:4] of register index 0 and fld_lim is bits [15:4] of index 1. A 32-bit request hits when base <= address <= limit, and both ends are inclusive.
- R3: A request that has the 64-bit flag set never hits the non-prefetchable window.
- R4: The prefetchable base is {index 4[31:0], index 2[15:4], 20'h00000}. The prefetchable limit is {index 5[31:0], index 3[15:4], 20'hFFFFF}. The compare runs over all 64 bits and is inclusive at both ends.
- R5: For a request whose 64-bit flag is clear, address bits [63:32] are treated as zero by both windows.
- R6: A window whose rebuilt base is greater than its rebuilt limit matches no address.
- R7: The forward output is set when the request hits either window and bit 0 of register index 6 (memory enable) is set at request time. The hit outputs report the window matches whatever the state of the enable bit.
- R8: Bits [3:0] of the bound registers ignore writes. They read 4'h0 at indexes 0 and 1 and 4'h1 at indexes 2 and 3. Bits [31:16] of those registers read as zero.
- R9: The response valid output rises exactly one clock after each cycle with request valid, including back-to-back requests. While it is low, the forward and hit outputs are low.
- R10: Register indexes are 0 np base, 1 np limit, 2 pf base, 3 pf limit, 4 pf base upper, 5 pf limit upper and 6 control. Index 7 reads zero. Writes take effect at the clock edge, and read data follows the index combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register index |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data for cfg_addr_i |
| req_valid_i | input | 1 | Request strobe |
| req_addr_i | input | 64 | Request byte address |
| req_is64_i | input | 1 | Request carries a 64-bit address |
| rsp_valid_o | output | 1 | Decision valid, one cycle after request |
| rsp_fwd_o | output | 1 | Request is claimed and forwarded |
| rsp_np_hit_o | output | 1 | Request fell in the non-prefetchable window |
| rsp_pf_hit_o | output | 1 | Request fell in the prefetchable window |

## Verification
A wrong bound bit or a wrong fill of the low 20 bits moves a window edge by at least 1 MB. The next request placed on that edge then returns a wrong hit bit, one clock after it is issued. The sweeps therefore place requests on the first and last byte of each granule around every programmed bound. A stale or corrupted upper-half register shows as a hit on the wrong 4 GB page. A wrong enable gate shows as a forward bit that disagrees with the two hit bits in the same response. Register faults also show at once on the read-back port.

// File: rtl/mwd_pkg.sv
package mwd_pkg;
  localparam int unsigned ADDR_W   = 64;
  localparam int unsigned LO_W     = 32;
  localparam int unsigned GRAN_W   = 20;
  localparam int unsigned FLD_W    = LO_W - GRAN_W;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned IDX_W    = 3;
  localparam int unsigned N_WIN    = 2;

  localparam logic [IDX_W-1:0] IDX_NP_BASE = 3'd0;
  localparam logic [IDX_W-1:0] IDX_NP_LIM  = 3'd1;
  localparam logic [IDX_W-1:0] IDX_PF_BASE = 3'd2;
  localparam logic [IDX_W-1:0] IDX_PF_LIM  = 3'd3;
  localparam logic [IDX_W-1:0] IDX_PF_BHI  = 3'd4;
  localparam logic [IDX_W-1:0] IDX_PF_LHI  = 3'd5;
  localparam logic [IDX_W-1:0] IDX_CTRL    = 3'd6;

  localparam int unsigned WIN_NP = 0;
  localparam int unsigned WIN_PF = 1;

  typedef struct packed {
    logic [FLD_W-1:0]       np_base;
    logic [FLD_W-1:0]       np_lim;
    logic [FLD_W-1:0]       pf_base;
    logic [FLD_W-1:0]       pf_lim;
    logic [ADDR_W-LO_W-1:0] pf_base_hi;
    logic [ADDR_W-LO_W-1:0] pf_lim_hi;
    logic                   mem_en;
  } win_cfg_t;

  typedef struct packed {
    logic valid;
    logic fwd;
    logic np_hit;
    logic pf_hit;
  } decision_t;
endpackage

// File: rtl/mwd_cfg_regs.sv
module mwd_cfg_regs
  import mwd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output win_cfg_t         cfg_o
);
  localparam int unsigned PAD_W = REG_W - FLD_W - 4;
  // low nibble of the bound registers: 64-bit capable flag on prefetchable only
  localparam logic [3:0] NP_TYPE = 4'h0;
  localparam logic [3:0] PF_TYPE = 4'h1;

  win_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.np_base    <= '1;
      cfg_q.np_lim     <= '0;
      cfg_q.pf_base    <= '1;
      cfg_q.pf_lim     <= '0;
      cfg_q.pf_base_hi <= '0;
      cfg_q.pf_lim_hi  <= '0;
      cfg_q.mem_en     <= 1'b0;
    end else if (we_i) begin
      unique case (addr_i)
        IDX_NP_BASE: cfg_q.np_base    <= wdata_i[4 +: FLD_W];
        IDX_NP_LIM:  cfg_q.np_lim     <= wdata_i[4 +: FLD_W];
        IDX_PF_BASE: cfg_q.pf_base    <= wdata_i[4 +: FLD_W];
        IDX_PF_LIM:  cfg_q.pf_lim     <= wdata_i[4 +: FLD_W];
        IDX_PF_BHI:  cfg_q.pf_base_hi <= wdata_i;
        IDX_PF_LHI:  cfg_q.pf_lim_hi  <= wdata_i;
        IDX_CTRL:    cfg_q.mem_en     <= wdata_i[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      IDX_NP_BASE: rdata_o = {{PAD_W{1'b0}}, cfg_q.np_base, NP_TYPE};
      IDX_NP_LIM:  rdata_o = {{PAD_W{1'b0}}, cfg_q.np_lim,  NP_TYPE};
      IDX_PF_BASE: rdata_o = {{PAD_W{1'b0}}, cfg_q.pf_base, PF_TYPE};
      IDX_PF_LIM:  rdata_o = {{PAD_W{1'b0}}, cfg_q.pf_lim,  PF_TYPE};
      IDX_PF_BHI:  rdata_o = cfg_q.pf_base_hi;
      IDX_PF_LHI:  rdata_o = cfg_q.pf_lim_hi;
      IDX_CTRL:    rdata_o = {{(REG_W-1){1'b0}}, cfg_q.mem_en};
      default:     rdata_o = '0;
    endcase
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/mwd_window_cmp.sv
module mwd_window_cmp #(
  parameter int unsigned AW = 64
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] limit_i,
  input  logic [AW-1:0] addr_i,
  input  logic          allow_i,
  output logic          hit_o
);
  logic open_win, above_base, below_lim;

  // inverted bounds close the window
  assign open_win   = base_i <= limit_i;
  assign above_base = addr_i >= base_i;
  assign below_lim  = addr_i <= limit_i;
  assign hit_o      = allow_i & open_win & above_base & below_lim;
endmodule

// File: rtl/mem_window_decoder.sv
module mem_window_decoder
  import mwd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_addr_i,
  input  logic [REG_W-1:0]  cfg_wdata_i,
  output logic [REG_W-1:0]  cfg_rdata_o,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_is64_i,
  output logic              rsp_valid_o,
  output logic              rsp_fwd_o,
  output logic              rsp_np_hit_o,
  output logic              rsp_pf_hit_o
);
  localparam int unsigned HI_W = ADDR_W - LO_W;

  win_cfg_t           cfg;
  logic               mem_en;
  logic [ADDR_W-1:0]  eff_addr;
  logic [ADDR_W-1:0]  win_base [N_WIN];
  logic [ADDR_W-1:0]  win_lim  [N_WIN];
  logic [N_WIN-1:0]   win_allow;
  logic [N_WIN-1:0]   win_hit;
  decision_t          dec_d, dec_q;

  mwd_cfg_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .cfg_o   (cfg)
  );

  assign mem_en = cfg.mem_en;

  // 32-bit requests carry no upper half
  assign eff_addr = req_is64_i ? req_addr_i : {{HI_W{1'b0}}, req_addr_i[LO_W-1:0]};

  assign win_base[WIN_NP] = {{HI_W{1'b0}}, cfg.np_base, {GRAN_W{1'b0}}};
  assign win_lim [WIN_NP] = {{HI_W{1'b0}}, cfg.np_lim,  {GRAN_W{1'b1}}};
  assign win_base[WIN_PF] = {cfg.pf_base_hi, cfg.pf_base, {GRAN_W{1'b0}}};
  assign win_lim [WIN_PF] = {cfg.pf_lim_hi,  cfg.pf_lim,  {GRAN_W{1'b1}}};

  assign win_allow[WIN_NP] = ~req_is64_i;
  assign win_allow[WIN_PF] = 1'b1;

  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    mwd_window_cmp #(.AW(ADDR_W)) u_cmp (
      .base_i  (win_base[w]),
      .limit_i (win_lim[w]),
      .addr_i  (eff_addr),
      .allow_i (win_allow[w]),
      .hit_o   (win_hit[w])
    );
  end

  always_comb begin
    dec_d        = '0;
    dec_d.valid  = req_valid_i;
    dec_d.np_hit = req_valid_i & win_hit[WIN_NP];
    dec_d.pf_hit = req_valid_i & win_hit[WIN_PF];
    dec_d.fwd    = req_valid_i & mem_en & (|win_hit);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dec_q <= '0;
    else         dec_q <= dec_d;
  end

  assign rsp_valid_o  = dec_q.valid;
  assign rsp_fwd_o    = dec_q.fwd;
  assign rsp_np_hit_o = dec_q.np_hit;
  assign rsp_pf_hit_o = dec_q.pf_hit;
endmodule

// File: rtl/mwd_chk.sv
module mwd_chk
  import mwd_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_is64_i,
  input logic             mem_en_i,
  input logic [IDX_W-1:0] cfg_addr_i,
  input logic [REG_W-1:0] cfg_rdata_o,
  input logic             rsp_valid_o,
  input logic             rsp_fwd_o,
  input logic             rsp_np_hit_o,
  input logic             rsp_pf_hit_o
);
  // R9
  rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  // R9
  rsp_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  // R9
  rsp_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> !(rsp_fwd_o || rsp_np_hit_o || rsp_pf_hit_o));
  // R3
  np_no_wide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_is64_i) |=> !rsp_np_hit_o);
  // R7
  fwd_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_fwd_o == ((rsp_np_hit_o || rsp_pf_hit_o) && $past(mem_en_i))));
  // R8
  pf_type_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_addr_i == IDX_PF_BASE || cfg_addr_i == IDX_PF_LIM) |-> cfg_rdata_o[3:0] == 4'h1);
endmodule

bind mem_window_decoder mwd_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_is64_i   (req_is64_i),
  .mem_en_i     (mem_en),
  .cfg_addr_i   (cfg_addr_i),
  .cfg_rdata_o  (cfg_rdata_o),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_fwd_o    (rsp_fwd_o),
  .rsp_np_hit_o (rsp_np_hit_o),
  .rsp_pf_hit_o (rsp_pf_hit_o)
);

// File: tb/mem_window_decoder_bench.sv
`timescale 1ns/1ps
module mem_window_decoder_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        req_valid_i = 1'b0;
  logic [63:0] req_addr_i = '0;
  logic        req_is64_i = 1'b0;
  logic        rsp_valid_o, rsp_fwd_o, rsp_np_hit_o, rsp_pf_hit_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  mem_window_decoder u_mem_window_decoder (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = idx; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] idx, input logic [31:0] exp, input string req);
    @(negedge clk_i);
    cfg_addr_i = idx;
    #0.5;
    check(cfg_rdata_o == exp, req, 64'(cfg_rdata_o), 64'(exp));
  endtask

  // issue at negedge, decision registered at next posedge, sampled at following negedge
  task automatic req_chk(input logic [63:0] a, input bit w64, input bit e_np, input bit e_pf,
                         input bit e_fwd, input string req);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = a; req_is64_i = w64;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check(rsp_valid_o, {req, " R9 valid"}, 64'(rsp_valid_o), 64'd1);
    check({rsp_np_hit_o, rsp_pf_hit_o, rsp_fwd_o} == {e_np, e_pf, e_fwd}, req,
          64'({rsp_np_hit_o, rsp_pf_hit_o, rsp_fwd_o}), 64'({e_np, e_pf, e_fwd}));
  endtask

  function automatic bit in_win(input logic [63:0] b, input logic [63:0] l, input logic [63:0] a);
    return (b <= l) && (a >= b) && (a <= l);
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      check(1'b0, "watchdog", 64'd0, 64'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 / R8 reset read-back
    rd_chk(3'd0, 32'h0000_FFF0, "R1 np base reset");
    rd_chk(3'd1, 32'h0000_0000, "R1 np lim reset");
    rd_chk(3'd2, 32'h0000_FFF1, "R1 pf base reset");
    rd_chk(3'd3, 32'h0000_0001, "R1 pf lim reset");
    rd_chk(3'd6, 32'h0000_0000, "R1 ctrl reset");
    req_chk(64'h0, 1'b0, 0, 0, 0, "R1 low addr");
    req_chk(64'hFFF0_0000, 1'b0, 0, 0, 0, "R1 top addr");
    @(negedge clk_i);
    check(!rsp_valid_o && !rsp_fwd_o, "R9 idle after req", 64'({rsp_valid_o, rsp_fwd_o}), 64'd0);

    // R8 / R10 register map and low nibble
    wr(3'd0, 32'hFFFF_FFFF);
    rd_chk(3'd0, 32'h0000_FFF0, "R8 np nibble");
    wr(3'd3, 32'hFFFF_0000);
    rd_chk(3'd3, 32'h0000_0001, "R8 pf nibble");
    wr(3'd4, 32'h1234_5678);
    rd_chk(3'd4, 32'h1234_5678, "R10 pf base hi");
    wr(3'd7, 32'hFFFF_FFFF);
    rd_chk(3'd7, 32'h0, "R10 unused idx");
    wr(3'd4, 32'h0); wr(3'd3, 32'h0); wr(3'd0, 32'hFFF0);
    wr(3'd6, 32'h1);
    rd_chk(3'd6, 32'h1, "R10 ctrl");

    // R2 R3 R5 R6 np sweep, pf disabled
    for (int b = 0; b < 6; b++) begin
      for (int l = 0; l < 6; l++) begin
        wr(3'd0, 32'(b) << 4);
        wr(3'd1, 32'(l) << 4);
        for (int g = 0; g < 7; g++) begin
          for (int o = 0; o < 2; o++) begin
            logic [63:0] a;
            bit e;
            a = 64'(g) << 20 | (o != 0 ? 64'hF_FFFF : 64'h0);
            e = in_win(64'(b) << 20, (64'(l) << 20) | 64'hF_FFFF, a);
            req_chk(a | 64'hA5A5_0000_0000_0000, 1'b0, e, 0, e, "R2 R5 R6 np");
            req_chk(a, 1'b1, 0, 0, 0, "R3 np wide");
          end
        end
      end
    end
    wr(3'd0, 32'hFFF0); wr(3'd1, 32'h0);

    // R4 R5 R6 pf sweep, np disabled
    for (int bh = 0; bh < 2; bh++) begin
      for (int lh = 0; lh < 3; lh++) begin
        for (int bi = 0; bi < 3; bi++) begin
          for (int li = 0; li < 3; li++) begin
            logic [11:0] bf, lf;
            logic [63:0] pb, pl;
            bf = (bi == 0) ? 12'h000 : (bi == 1) ? 12'h003 : 12'hFFF;
            lf = (li == 0) ? 12'h000 : (li == 1) ? 12'h003 : 12'hFFF;
            wr(3'd2, {16'h0, bf, 4'h0});
            wr(3'd3, {16'h0, lf, 4'h0});
            wr(3'd4, 32'(bh));
            wr(3'd5, 32'(lh));
            pb = {32'(bh), bf, 20'h0};
            pl = {32'(lh), lf, 20'hF_FFFF};
            for (int h = 0; h < 4; h++) begin
              for (int gi = 0; gi < 5; gi++) begin
                for (int o = 0; o < 2; o++) begin
                  logic [11:0] gf;
                  logic [63:0] a;
                  bit e;
                  gf = (gi == 0) ? 12'h000 : (gi == 1) ? 12'h002 : (gi == 2) ? 12'h003 :
                       (gi == 3) ? 12'h004 : 12'hFFF;
                  a = {32'(h), gf, (o != 0) ? 20'hF_FFFF : 20'h0};
                  e = in_win(pb, pl, a);
                  req_chk(a, 1'b1, 0, e, e, "R4 R6 pf wide");
                  e = in_win(pb, pl, {32'h0, a[31:0]});
                  req_chk(a, 1'b0, 0, e, e, "R5 pf narrow");
                end
              end
            end
          end
        end
      end
    end

    // R7 enable gate: both windows open
    wr(3'd0, 32'h0010); wr(3'd1, 32'h0010);
    wr(3'd2, 32'h0020); wr(3'd3, 32'h0020); wr(3'd4, 32'h0); wr(3'd5, 32'h0);
    req_chk(64'h0010_0000, 1'b0, 1, 0, 1, "R7 np en");
    wr(3'd6, 32'h0);
    req_chk(64'h0010_0000, 1'b0, 1, 0, 0, "R7 np disabled");
    req_chk(64'h0020_0000, 1'b1, 0, 1, 0, "R7 pf disabled");
    req_chk(64'h0030_0000, 1'b1, 0, 0, 0, "R7 miss");
    wr(3'd6, 32'h1);

    // R9 back-to-back
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = 64'h0010_0000; req_is64_i = 1'b0;
    @(negedge clk_i);
    req_addr_i = 64'h0020_0000; req_is64_i = 1'b1;
    check(rsp_valid_o && rsp_np_hit_o && !rsp_pf_hit_o, "R9 b2b first",
          64'({rsp_valid_o, rsp_np_hit_o, rsp_pf_hit_o}), 64'b110);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check(rsp_valid_o && !rsp_np_hit_o && rsp_pf_hit_o, "R9 b2b second",
          64'({rsp_valid_o, rsp_np_hit_o, rsp_pf_hit_o}), 64'b101);
    @(negedge clk_i);
    check(!rsp_valid_o, "R9 b2b end", 64'(rsp_valid_o), 64'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule